// File: doc/BRIEF.md
# Three-Channel LED Effect Dimmer

This block drives three LED channels with pulse-width modulation. All three channels share one period counter, so their periods are equal and their on-phases all begin on the same clock. A pushbutton steps the block through eight fixed lighting patterns. The button is synchronized and debounced inside the block, and each accepted press moves to the next pattern. After pattern seven the sequence returns to pattern zero. No other input selects the pattern.

A two-bit battery status from an external comparator or converter scales every channel. A full battery leaves the duties unchanged, a half-charged battery halves them, and a depleted battery puts the block to sleep with every output dark. Sleep ends only when the status reports a full battery again, which gives the status hysteresis. New duty values take effect only at the start of a PWM period, so no period is ever cut short.

Top module: `led_fx_pwm`

## Requirements
- R1: All three channels share one period of 2^DUTY_W ticks (one tick every PRESCALE clocks), and their high phases start on the same clock.
- R2: While reset is held and after it is released, sleep_o is 1, all pwm_o bits are 0, and the pattern is 0.
- R3: In each period, a channel is high for exactly as many ticks as its compare value, out of 2^DUTY_W ticks. The output lags the period counter by one clock.
- R4: Fixed patterns, with values given for DUTY_W=8 (hi=229, mid=127, lo=25, max=255). Pattern 0 is {hi,0,0}. Pattern 1 is {0,hi,0}. Pattern 2 is {0,0,hi}. Pattern 3 is {max,max,max}. Pattern 4 is {mid,mid,mid}. Pattern 5 is {hi,mid,lo}. Pattern 6 is all 0. Each triple is listed as {ch0,ch1,ch2}.
- R5: Each accepted press adds one to the pattern number, and pattern 7 goes to 0. The pattern changes at no other time.
- R6: The button is synchronized by two flops. A press is accepted only when the synchronized level differs from the held level for DEB_CYCLES clocks in a row. Shorter pulses are ignored, and one press gives exactly one step.
- R7: Pattern 7 sweeps each channel in a triangle between lo and hi. A phase counter advances every STEP_CYCLES clocks over 2*(hi-lo) steps. Channel k reads that phase plus k/3 of the sweep period.
- R8: Battery code 2'b11 (full) passes duties unchanged. Code 2'b10 (half) halves them, rounding down.
- R9: Codes 2'b00 and 2'b01 set sleep three clocks after the input changes, and all outputs are forced low while sleep_o is 1. Only code 2'b11 clears sleep. Code 2'b10 keeps the block asleep.
- R10: Compare values are loaded only when the period counter wraps. A change of pattern or battery code takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Raw pushbutton level, asynchronous, 1 = pressed |
| bat_i | input | 2 | Battery status code |
| pwm_o | output | 3 | PWM outputs, bit k drives channel k |
| sleep_o | output | 1 | 1 while the block is asleep |

## Verification
The assertions assume that btn_i and bat_i are slow, level-type signals. The mode and sleep checks assume that each change reaches the synchronizers and is then held. The stimulus changes both inputs only on falling clock edges and holds each level for many clocks. Short button pulses are used only as deliberate glitches kept below the debounce length. The bench applies battery codes only as full, half and depleted steps, well apart in time, so that every one reaches the sleep register.

// File: rtl/led_fx_pkg.sv
package led_fx_pkg;

  typedef enum logic [1:0] {
    BAT_DEAD0 = 2'b00,
    BAT_DEAD1 = 2'b01,
    BAT_HALF  = 2'b10,
    BAT_FULL  = 2'b11
  } bat_code_e;

  typedef enum logic [2:0] {
    PAT_SOLO0    = 3'd0,
    PAT_SOLO1    = 3'd1,
    PAT_SOLO2    = 3'd2,
    PAT_ALL_MAX  = 3'd3,
    PAT_ALL_MID  = 3'd4,
    PAT_GRADIENT = 3'd5,
    PAT_DARK     = 3'd6,
    PAT_SWEEP    = 3'd7
  } pattern_e;

  localparam int NUM_CH = 3;

endpackage

// File: rtl/fx_btn_filter.sv
module fx_btn_filter #(
  parameter int DEB_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o
);
  localparam int DW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);

  logic sync1_q, sync2_q;
  logic held_q, held_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic press_d;

  always_comb begin
    held_d  = held_q;
    dcnt_d  = dcnt_q;
    press_d = 1'b0;
    if (sync2_q == held_q) begin
      dcnt_d = '0;
    end else if (dcnt_q == DEB_LAST) begin
      held_d  = sync2_q;
      dcnt_d  = '0;
      press_d = sync2_q;
    end else begin
      dcnt_d = dcnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      held_q  <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      sync1_q <= btn_i;
      sync2_q <= sync1_q;
      held_q  <= held_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign press_o = press_d;

  // R6: an accepted press is a single-clock event
  p_single_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/fx_pattern.sv
module fx_pattern
  import led_fx_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int STEP_CYCLES = 245000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           press_i,
  output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_o
);
  localparam int MAXV  = (1 << DUTY_W) - 1;
  localparam int D_HI  = (MAXV * 9) / 10;
  localparam int D_LO  = MAXV / 10;
  localparam int D_MID = MAXV / 2;
  localparam int SPAN  = D_HI - D_LO;
  localparam int PER   = 2 * SPAN;
  localparam int THIRD = PER / 3;
  localparam int PH_W  = $clog2(PER);
  localparam int SW    = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;

  localparam logic [DUTY_W-1:0] V_HI  = DUTY_W'(D_HI);
  localparam logic [DUTY_W-1:0] V_MID = DUTY_W'(D_MID);
  localparam logic [DUTY_W-1:0] V_LO  = DUTY_W'(D_LO);
  localparam logic [DUTY_W-1:0] V_MAX = DUTY_W'(MAXV);
  localparam logic [PH_W:0]     SPAN_V = (PH_W+1)'(SPAN);
  localparam logic [PH_W:0]     PER_V  = (PH_W+1)'(PER);
  localparam logic [PH_W-1:0]   PH_LAST = PH_W'(PER - 1);
  localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_CYCLES - 1);

  pattern_e mode_q, mode_d;
  logic [SW-1:0]   scnt_q, scnt_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [NUM_CH-1:0][DUTY_W-1:0] ramp_w;

  // next-state: pattern selector and sweep phase
  always_comb begin
    mode_d  = press_i ? pattern_e'(mode_q + 3'd1) : mode_q;
    scnt_d  = scnt_q + SW'(1);
    phase_d = phase_q;
    if (scnt_q == STEP_LAST) begin
      scnt_d  = '0;
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PAT_SOLO0;
      scnt_q  <= '0;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_d;
      scnt_q  <= scnt_d;
      phase_q <= phase_d;
    end
  end

  // one triangle per channel, each shifted by a third of the sweep
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ramp
    logic [PH_W:0] sum_w, chp_w;
    assign sum_w = {1'b0, phase_q} + (PH_W+1)'(k * THIRD);
    assign chp_w = (sum_w >= PER_V) ? sum_w - PER_V : sum_w;
    assign ramp_w[k] = (chp_w < SPAN_V) ? DUTY_W'(D_LO + int'(chp_w))
                                        : DUTY_W'(D_LO + PER - int'(chp_w));

    // R7: sweeping channels stay inside the low/high bounds
    p_ramp_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PAT_SWEEP) |-> (duty_o[k] >= V_LO && duty_o[k] <= V_HI));
  end

  always_comb begin
    duty_o = '0;
    case (mode_q)
      PAT_SOLO0:    duty_o[0] = V_HI;
      PAT_SOLO1:    duty_o[1] = V_HI;
      PAT_SOLO2:    duty_o[2] = V_HI;
      PAT_ALL_MAX:  duty_o = {V_MAX, V_MAX, V_MAX};
      PAT_ALL_MID:  duty_o = {V_MID, V_MID, V_MID};
      PAT_GRADIENT: duty_o = {V_LO, V_MID, V_HI};
      PAT_DARK:     duty_o = '0;
      PAT_SWEEP:    duty_o = ramp_w;
      default:      duty_o = '0;
    endcase
  end

  // R5: the pattern only moves forward by one, and only on a press
  p_mode_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> (mode_q == pattern_e'($past(mode_q) + 3'd1)));
  p_mode_needs_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(press_i));
  // R7: the phase advances by one or wraps to zero
  p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> (phase_q == '0 || phase_q == $past(phase_q) + PH_W'(1)));

endmodule

// File: rtl/fx_battery_gate.sv
module fx_battery_gate
  import led_fx_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    bat_i,
  input  logic [NUM_CH-1:0][DUTY_W-1:0] duty_i,
  output logic [NUM_CH-1:0][DUTY_W-1:0] duty_o,
  output logic                          sleep_o
);
  logic [1:0] bsync1_q;
  bat_code_e  bsync2_q;
  logic       sleep_q, sleep_d;

  always_comb begin
    sleep_d = sleep_q;
    if (!bsync2_q[1])
      sleep_d = 1'b1;
    else if (bsync2_q == BAT_FULL)
      sleep_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync1_q <= 2'b00;
      bsync2_q <= BAT_DEAD0;
      sleep_q  <= 1'b1;
    end else begin
      bsync1_q <= bat_i;
      bsync2_q <= bat_code_e'(bsync1_q);
      sleep_q  <= sleep_d;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_scale
    always_comb begin
      if (sleep_q)
        duty_o[k] = '0;
      else if (bsync2_q == BAT_FULL)
        duty_o[k] = duty_i[k];
      else if (bsync2_q == BAT_HALF)
        duty_o[k] = duty_i[k] >> 1;
      else
        duty_o[k] = '0;
    end
  end

  assign sleep_o = sleep_q;

  // R9: leaving sleep needs a full-battery code; a depleted code always sleeps
  p_wake_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> ($past(bsync2_q) == BAT_FULL));
  p_sleep_on_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bsync2_q[1] |=> sleep_q);

endmodule

// File: rtl/fx_pwm_bank.sv
module fx_pwm_bank
  import led_fx_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 195
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0][DUTY_W-1:0] duty_i,
  input  logic                          dark_i,
  output logic [NUM_CH-1:0]             pwm_o
);
  logic tick;
  logic wrap;
  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic [NUM_CH-1:0][DUTY_W-1:0] cmp_q, cmp_d;
  logic [NUM_CH-1:0] pwm_q, pwm_d;

  if (PRESCALE > 1) begin : g_div
    localparam int PW = $clog2(PRESCALE);
    logic [PW-1:0] pc_q, pc_d;
    assign tick = (pc_q == PW'(PRESCALE - 1));
    assign pc_d = tick ? '0 : pc_q + PW'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
    end
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  assign wrap = tick && (cnt_q == {DUTY_W{1'b1}});

  always_comb begin
    cnt_d = tick ? cnt_q + DUTY_W'(1) : cnt_q;
    cmp_d = wrap ? duty_i : cmp_q;
    for (int k = 0; k < NUM_CH; k++)
      pwm_d[k] = (cnt_q < cmp_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      pwm_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q & ~{NUM_CH{dark_i}};

  // R10: compare registers only change right after a counter wrap
  p_latch_on_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> $past(wrap));

endmodule

// File: rtl/led_fx_pwm.sv
module led_fx_pwm
  import led_fx_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int PRESCALE    = 195,
  parameter int DEB_CYCLES  = 1000000,
  parameter int STEP_CYCLES = 245000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_i,
  input  logic [1:0] bat_i,
  output logic [2:0] pwm_o,
  output logic       sleep_o
);
  logic press;
  logic sleep_w;
  logic [NUM_CH-1:0][DUTY_W-1:0] raw_duty, gated_duty;

  fx_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .press_o(press));

  fx_pattern #(.DUTY_W(DUTY_W), .STEP_CYCLES(STEP_CYCLES)) u_pat (
    .clk(clk), .rst_n(rst_n), .press_i(press), .duty_o(raw_duty));

  fx_battery_gate #(.DUTY_W(DUTY_W)) u_bat (
    .clk(clk), .rst_n(rst_n), .bat_i(bat_i), .duty_i(raw_duty),
    .duty_o(gated_duty), .sleep_o(sleep_w));

  fx_pwm_bank #(.DUTY_W(DUTY_W), .PRESCALE(PRESCALE)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_i(gated_duty), .dark_i(sleep_w),
    .pwm_o(pwm_o));

  assign sleep_o = sleep_w;

  // R9: every output is dark while asleep
  p_dark_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (pwm_o == 3'b000));

endmodule

// File: tb/sim_led_fx_pwm.sv
module sim_led_fx_pwm;
  localparam int DEB  = 16;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic [1:0] bat = 2'b00;
  logic [2:0] pwm;
  logic sleep;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  led_fx_pwm #(.DUTY_W(8), .PRESCALE(1), .DEB_CYCLES(DEB), .STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .bat_i(bat), .pwm_o(pwm), .sleep_o(sleep));

  // ---------------- reference model ----------------
  int m_b1 = 0, m_b2 = 0, m_lvl = 0, m_dc = 0, m_mode = 0;
  int m_bat1 = 0, m_bat2 = 0, m_sleep = 1, m_sc = 0, m_ph = 0, m_cnt = 0;
  int m_cmp[3] = '{0, 0, 0};
  int m_pq[3]  = '{0, 0, 0};

  function automatic int pattern_duty(int mode, int k, int ph);
    int p;
    p = (ph + k * 136) % 408;
    case (mode)
      0: return (k == 0) ? 229 : 0;
      1: return (k == 1) ? 229 : 0;
      2: return (k == 2) ? 229 : 0;
      3: return 255;
      4: return 127;
      5: return (k == 0) ? 229 : (k == 1) ? 127 : 25;
      6: return 0;
      default: return (p < 204) ? 25 + p : 25 + 408 - p;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_b1 = 0; m_b2 = 0; m_lvl = 0; m_dc = 0; m_mode = 0;
      m_bat1 = 0; m_bat2 = 0; m_sleep = 1; m_sc = 0; m_ph = 0; m_cnt = 0;
      for (int k = 0; k < 3; k++) begin m_cmp[k] = 0; m_pq[k] = 0; end
    end else begin
      int d;
      bit press;
      press = 0;
      if (m_b2 == m_lvl) m_dc = 0;
      else if (m_dc == DEB - 1) begin press = (m_b2 == 1); m_lvl = m_b2; m_dc = 0; end
      else m_dc = m_dc + 1;
      for (int k = 0; k < 3; k++) m_pq[k] = (m_cnt < m_cmp[k]) ? 1 : 0;
      if (m_cnt == 255) begin
        for (int k = 0; k < 3; k++) begin
          d = pattern_duty(m_mode, k, m_ph);
          if (m_sleep == 1) d = 0;
          else if (m_bat2 == 2) d = d / 2;
          else if (m_bat2 != 3) d = 0;
          m_cmp[k] = d;
        end
      end
      m_cnt = (m_cnt + 1) % 256;
      if (m_sc == STEP - 1) begin m_sc = 0; m_ph = (m_ph + 1) % 408; end
      else m_sc = m_sc + 1;
      if (press) m_mode = (m_mode + 1) % 8;
      if (m_bat2 < 2) m_sleep = 1;
      else if (m_bat2 == 3) m_sleep = 0;
      m_b2 = m_b1; m_b1 = int'(btn);
      m_bat2 = m_bat1; m_bat1 = int'(bat);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++) begin
        int e;
        e = (m_sleep == 0) ? m_pq[k] : 0;
        checks++;
        if (int'(pwm[k]) != e) begin
          fails++;
          $display("FAIL %s ch%0d pwm: actual %0d expected %0d",
                   (m_mode == 7) ? "R7" : (m_bat2 == 2) ? "R8" : "R3", k, pwm[k], e);
        end
      end
      checks++;
      if (int'(sleep) != m_sleep) begin
        fails++;
        $display("FAIL R9 sleep: actual %0d expected %0d", sleep, m_sleep);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(string tag, int k, int exp);
    int hi;
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm[k]) hi++;
    end
    chk(tag, hi, exp);
  endtask

  task automatic press_btn();
    @(negedge clk); btn = 1'b1;
    wait_cyc(DEB + 6);
    btn = 1'b0;
    wait_cyc(DEB + 6);
    wait_cyc(520);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    wait_cyc(3);
    chk("R2 reset sleep", int'(sleep), 1);
    chk("R2 reset pwm", int'(pwm), 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(20);
    chk("R2 sleep after reset", int'(sleep), 1);
    chk("R2 dark after reset", int'(pwm), 0);

    bat = 2'b11;
    wait_cyc(600);
    chk("R9 awake on full", int'(sleep), 0);
    measure("R4 pattern0 ch0", 0, 229);
    measure("R4 pattern0 ch1", 1, 0);

    // short glitch must be ignored
    @(negedge clk); btn = 1'b1;
    wait_cyc(DEB - 4);
    btn = 1'b0;
    wait_cyc(600);
    measure("R6 glitch ignored ch0", 0, 229);
    measure("R6 glitch ignored ch1", 1, 0);

    press_btn();
    measure("R5 pattern1 ch1", 1, 229);
    measure("R5 pattern1 ch0", 0, 0);
    press_btn();
    measure("R4 pattern2 ch2", 2, 229);
    press_btn();
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        if (pwm != 3'b000 && pwm != 3'b111) bad++;
      end
      chk("R1 channels aligned", bad, 0);
    end
    measure("R3 pattern3 ch1", 1, 255);
    press_btn();
    measure("R4 pattern4 ch2", 2, 127);
    bat = 2'b10;
    wait_cyc(600);
    measure("R8 half scaling ch0", 0, 63);
    chk("R8 half stays awake", int'(sleep), 0);
    bat = 2'b11;
    wait_cyc(600);
    press_btn();
    measure("R4 pattern5 ch0", 0, 229);
    measure("R4 pattern5 ch1", 1, 127);
    measure("R4 pattern5 ch2", 2, 25);
    press_btn();
    measure("R4 pattern6 ch0", 0, 0);
    press_btn();
    wait_cyc(3300);  // R7 sweep compared by the model over two sweeps
    press_btn();
    measure("R5 wrap to pattern0 ch0", 0, 229);

    // R10: battery change mid-period must not cut the running period
    begin
      int run;
      while (pwm[0] !== 1'b1) @(negedge clk);
      while (pwm[0] !== 1'b0) @(negedge clk);
      while (pwm[0] !== 1'b1) @(negedge clk);
      run = 1;
      repeat (50) begin @(negedge clk); if (pwm[0]) run++; end
      bat = 2'b10;
      while (pwm[0] === 1'b1) begin @(negedge clk); if (pwm[0]) run++; end
      chk("R10 running period kept", run, 229);
      while (pwm[0] !== 1'b1) @(negedge clk);
      run = 1;
      @(negedge clk);
      while (pwm[0] === 1'b1) begin run++; @(negedge clk); end
      chk("R10 next period scaled", run, 114);
    end

    bat = 2'b11;
    wait_cyc(600);
    bat = 2'b01;
    wait_cyc(4);
    chk("R9 sleep on depleted", int'(sleep), 1);
    chk("R9 dark on depleted", int'(pwm), 0);
    bat = 2'b10;
    wait_cyc(600);
    chk("R9 half keeps sleep", int'(sleep), 1);
    chk("R9 half keeps dark", int'(pwm), 0);
    bat = 2'b11;
    wait_cyc(600);
    chk("R9 wake on full", int'(sleep), 0);
    measure("R9 duty after wake", 0, 229);

    summary();
    $finish;
  end

endmodule